// File: doc/BRIEF.md
# Two-Tier Weighted Round-Robin Slave Arbiter

This block decides which of ten requesting masters owns one slave port of a multi-layer bus. Four masters (indices 0, 1, 2 and 9) form a fixed-priority tier. Whenever any of them is requesting, one of them is served before anyone else. The remaining six masters (indices 3 to 8) share the slave in rotation. Each of these six may keep the slave for a burst of consecutive completed transfers. The burst limit is a weight that can be changed at runtime.

The slave pulses `xfer_done` on every cycle in which it accepts a transfer from the current owner. A master that raises its lock line along with its request keeps the slave until it drops either one. Weights are written through a single-cycle write strobe that carries a master index and a value. A write changes the stored weight, and a master picks up its weight only at the moment it is granted.

Top module: `wrr_slave_arbiter`

## Requirements
- R1: During and right after reset `gnt` is all zeros and `gnt_id` is 0. Every weight starts at 1, so the rotating tier begins with one transfer per turn, and the rotation pointer starts at master 3.
- R2: Inside the fixed tier, master 1 beats master 0, master 0 beats master 2, and master 2 beats master 9.
- R3: When a new grant is issued and any of masters 0, 1, 2 or 9 is requesting, a fixed-tier master receives it.
- R4: Among masters 3 to 8, the search starts at the index after the last rotating master granted, and wraps from 8 back to 3.
- R5: A rotating master granted with weight W keeps the grant for at most W completed transfers (cycles with `xfer_done` high). After the W-th transfer, arbitration runs again.
- R6: A write with `wr_en` high and `wr_idx` between 3 and 8 sets that master's weight. A value of 0 is stored as 1, and a value above 32 is stored as 32. A write with any other `wr_idx` changes no weight.
- R7: A master latches its weight when it is granted. A write during its tenure does not change the current burst and applies from its next grant.
- R8: While the owner holds both its request and its lock line high, the grant does not move, whatever else is requested.
- R9: A grant ends when the owner drops its request. A rotating owner without lock also loses the grant on any completed transfer while a fixed-tier master is requesting.
- R10: While the owner keeps requesting, the grant changes only on a clock edge where `xfer_done` is high.
- R11: `gnt` is one-hot or zero. When it is non-zero, `gnt_id` holds the index of its set bit, and otherwise `gnt_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 10 | Per-master request |
| lock | input | 10 | Per-master lock, meaningful with request |
| xfer_done | input | 1 | Slave accepted a transfer from the owner this cycle |
| wr_en | input | 1 | Weight write strobe |
| wr_idx | input | 4 | Master index for the weight write |
| wr_data | input | 6 | Weight value to write (clamped to 1..WMAX) |
| gnt | output | 10 | One-hot grant, registered |
| gnt_id | output | 4 | Index of the granted master |

## Verification
The bench builds the arbiter with its default `WMAX` of 32. With that value, a written 40 clamps to the real ceiling, and a full 32-transfer burst can be counted cycle by cycle against the rotation that follows it. The 6-bit write field at this setting can also carry values past the ceiling, so the upper clamp is reachable from the port. The directed cases cover:
- tier ordering;
- pointer wrap;
- weight latching during a burst;
- lock holding against a waiting fixed master;
- preemption of a rotating owner.

A long randomised phase then compares the grant every cycle against a behavioural model of the rules.

// File: rtl/wrr_slave_arbiter.sv
module wrr_slave_arbiter #(
  parameter int WMAX = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [9:0]                    req,
  input  logic [9:0]                    lock,
  input  logic                          xfer_done,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_idx,
  input  logic [$clog2(WMAX+1)-1:0]     wr_data,
  output logic [9:0]                    gnt,
  output logic [3:0]                    gnt_id
);
  localparam int NM    = 10;
  localparam int IW    = 4;
  localparam int RRN   = 6;
  localparam int RR_LO = 3;
  localparam int WW    = $clog2(WMAX+1);
  localparam int OW    = $clog2(RRN);

  logic          own_v;
  logic [IW-1:0] own;
  logic [WW-1:0] used, wlim;
  logic [OW-1:0] ptr;
  logic [WW-1:0] wt [RRN];

  logic          fix_hit, rr_hit, own_req, own_rr, keep, hold, cnt_up;
  logic [IW-1:0] fix_id;
  logic [OW-1:0] rr_off;

  assign fix_hit = req[1] | req[0] | req[2] | req[9];
  assign own_req = own_v & req[own];
  assign own_rr  = (own >= IW'(RR_LO)) && (own <= IW'(RR_LO + RRN - 1));
  assign keep    = lock[own] | (own_rr & ~fix_hit & ((used + WW'(1)) < wlim));
  assign hold    = own_req & (~xfer_done | keep);
  assign cnt_up  = own_req & xfer_done & keep;

  always_comb begin
    fix_id = '0;
    if (req[9]) fix_id = IW'(9);
    if (req[2]) fix_id = IW'(2);
    if (req[0]) fix_id = IW'(0);
    if (req[1]) fix_id = IW'(1);
  end

  always_comb begin
    rr_hit = 1'b0;
    rr_off = '0;
    for (int k = RRN - 1; k >= 0; k--) begin
      int o;
      o = (int'(ptr) + k) % RRN;
      if (req[RR_LO + o]) begin
        rr_hit = 1'b1;
        rr_off = OW'(o);
      end
    end
  end

  function automatic logic [WW-1:0] clamp_w(input logic [WW-1:0] d);
    if (d == '0) return WW'(1);
    if (d > WW'(WMAX)) return WW'(WMAX);
    return d;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RRN; i++) wt[i] <= WW'(1);
    end else if (wr_en) begin
      for (int i = 0; i < RRN; i++)
        if (wr_idx == IW'(RR_LO + i)) wt[i] <= clamp_w(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v <= 1'b0;
      own   <= '0;
      used  <= '0;
      wlim  <= WW'(1);
      ptr   <= '0;
    end else if (cnt_up) begin
      if (used != WW'(WMAX)) used <= used + WW'(1);
    end else if (!hold) begin
      used <= '0;
      if (fix_hit) begin
        own_v <= 1'b1;
        own   <= fix_id;
      end else if (rr_hit) begin
        own_v <= 1'b1;
        own   <= IW'(rr_off) + IW'(RR_LO);
        wlim  <= wt[rr_off];
        ptr   <= (rr_off == OW'(RRN - 1)) ? '0 : rr_off + OW'(1);
      end else begin
        own_v <= 1'b0;
      end
    end
  end

  assign gnt    = own_v ? (NM'(1) << own) : '0;
  assign gnt_id = own_v ? own : '0;

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_id_r11: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |-> gnt[gnt_id]);
  p_gnt_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (|(gnt & $past(req))));
  p_midxfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt & req)) && !xfer_done) |=> $stable(gnt));
  p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req & lock)) |=> $stable(gnt));
  p_fixfirst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt[8:3]) && !$stable(gnt)) |-> !$past(req[0] | req[1] | req[2] | req[9]));
  p_fixord_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[9] && !$stable(gnt)) |-> !$past(req[0] | req[1] | req[2]));
endmodule

// File: tb/sim_wrr_slave_arbiter.sv
`timescale 1ns/1ps
module sim_wrr_slave_arbiter;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [9:0] req = '0, lock = '0;
  logic       xfer_done = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [5:0] wr_data = '0;
  logic [9:0] gnt;
  logic [3:0] gnt_id;

  wrr_slave_arbiter u0 (.clk(clk), .rst_n(rst_n), .req(req), .lock(lock),
    .xfer_done(xfer_done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .gnt(gnt), .gnt_id(gnt_id));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;

  int m_own = -1, m_used = 0, m_lim = 1, m_ptr = 3;
  int m_wt [10];
  int ord [$] = '{1, 0, 2, 9};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = -1; m_used = 0; m_lim = 1; m_ptr = 3;
      foreach (m_wt[i]) m_wt[i] = 1;
    end else begin
      bit fx, orq, kp;
      int pick;
      fx  = req[0] | req[1] | req[2] | req[9];
      orq = (m_own >= 0) && req[m_own];
      kp  = orq && (lock[m_own] || (m_own >= 3 && m_own <= 8 && !fx && m_used + 1 < m_lim));
      if (orq && !xfer_done) begin
      end else if (kp) begin
        if (m_used < 32) m_used++;
      end else begin
        pick = -1;
        foreach (ord[i]) if (pick < 0 && req[ord[i]]) pick = ord[i];
        if (pick >= 0) begin
          m_own = pick; m_used = 0;
        end else begin
          for (int k = 0; k < 6; k++) begin
            int c;
            c = 3 + ((m_ptr - 3 + k) % 6);
            if (pick < 0 && req[c]) pick = c;
          end
          if (pick >= 0) begin
            m_own = pick; m_used = 0; m_lim = m_wt[pick];
            m_ptr = (pick == 8) ? 3 : pick + 1;
          end else m_own = -1;
        end
      end
      if (wr_en && wr_idx >= 3 && wr_idx <= 8)
        m_wt[wr_idx] = (wr_data == 0) ? 1 : ((wr_data > 32) ? 32 : int'(wr_data));
    end
  end

  // per-cycle model comparison: R2 R3 R4 R5 R8 R9 R10 R11
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      logic [9:0] eg;
      logic [3:0] ei;
      eg = (m_own < 0) ? 10'd0 : (10'd1 << m_own);
      ei = (m_own < 0) ? 4'd0 : 4'(m_own);
      n_cmp++;
      if (gnt !== eg || gnt_id !== ei) begin
        n_bad++;
        $display("FAIL R11/model t=%0t: gnt=%b id=%0d expected gnt=%b id=%0d",
                 $time, gnt, gnt_id, eg, ei);
      end
    end
  end

  function automatic logic [9:0] b(input int i);
    return 10'd1 << i;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [9:0] exp);
    n_cmp++;
    if (gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected %b", tag, gnt, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [5:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(); chk("R1 idle after reset", '0);

    req = b(0) | b(1) | b(2) | b(9);
    tick(); chk("R2 master1 first", b(1));
    req[1] = 1'b0; tick(); chk("R2 master0 next", b(0));
    req[0] = 1'b0; tick(); chk("R2 master2 next", b(2));
    req[2] = 1'b0; tick(); chk("R2 master9 last", b(9));
    req = '0; tick();

    req = b(3) | b(9);
    tick(); chk("R3 fixed before rotating", b(9));
    req[9] = 1'b0; tick(); chk("R3 rotating after fixed", b(3));
    req = '0; tick();

    req = b(4) | b(7); xfer_done = 1'b1;
    tick(); chk("R4 first 4", b(4));
    tick(); chk("R1 R4 weight one rotates to 7", b(7));
    tick(); chk("R4 back to 4", b(4));
    req = b(3) | b(8);
    tick(); chk("R4 search reaches 8", b(8));
    tick(); chk("R4 wrap 8 to 3", b(3));
    req = '0; xfer_done = 1'b0; tick();

    wr(4'd5, 6'd0);
    wr(4'd4, 6'd40);
    wr(4'd11, 6'd4);
    wr(4'd1, 6'd7);
    req = b(3) | b(4); xfer_done = 1'b1;
    tick();
    n = 0;
    while (gnt == b(4) && n < 40) begin n++; tick(); end
    n_cmp++;
    if (n != 32) begin
      n_bad++;
      $display("FAIL R6 clamp to 32: burst=%0d expected 32", n);
    end
    chk("R6 master3 weight untouched", b(3));
    tick(); chk("R6 back to 4", b(4));
    req = '0; xfer_done = 1'b0; tick();

    wr(4'd6, 6'd3);
    req = b(5) | b(6); xfer_done = 1'b1;
    tick(); chk("R6 zero clamps to one", b(5));
    tick(); chk("R5 master6 granted", b(6));
    wr_en = 1'b1; wr_idx = 4'd6; wr_data = 6'd1;
    tick(); wr_en = 1'b0;
    chk("R7 burst keeps latched weight", b(6));
    tick(); chk("R5 third transfer", b(6));
    tick(); chk("R5 burst of three ends", b(5));
    tick(); chk("R7 new weight next grant", b(6));
    tick(); chk("R7 new weight one", b(5));
    req = '0; xfer_done = 1'b0; tick();

    req = b(7); lock = b(7); xfer_done = 1'b1;
    tick(); chk("R8 lock owner granted", b(7));
    req[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin tick(); chk("R8 lock holds", b(7)); end
    lock = '0; tick(); chk("R8 released to fixed", b(1));
    req = '0; xfer_done = 1'b0; tick();

    wr(4'd3, 6'd4);
    req = b(3);
    tick(); chk("R9 setup master3", b(3));
    req[0] = 1'b1;
    for (int i = 0; i < 3; i++) begin tick(); chk("R10 no switch mid transfer", b(3)); end
    xfer_done = 1'b1; tick(); chk("R9 fixed preempts after transfer", b(0));
    req = b(3); xfer_done = 1'b0;
    tick(); chk("R9 owner drop returns to 3", b(3));
    req = b(5); tick(); chk("R9 drop request ends grant", b(5));
    req = '0; tick();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      req[8:3] = r[5:0];
      req[0] = (r[9:7] == 0); req[1] = (r[12:10] == 0);
      req[2] = (r[15:13] == 0); req[9] = (r[18:16] == 0);
      lock = (r[21:19] == 0) ? req : '0;
      xfer_done = r[22];
      wr_en = (r[26:23] == 0);
      wr_idx = 4'($urandom_range(0, 15));
      wr_data = 6'($urandom_range(0, 63));
      tick();
    end
    req = '0; lock = '0; wr_en = 1'b0; xfer_done = 1'b0;
    tick();

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!fin) begin
      fin = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual unfinished expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule